// File: doc/BRIEF.md
# Flash Program Data Staging Sequencer

This block stages the data for one flash programming operation and then hands it to the flash array one 32-bit word at a time. Software fills eight 32-bit staging words over a simple register port. It then issues a program command that carries a target address and a size code. The sequencer walks through the staged words in ascending order. It presents each word with a word-aligned address on a valid/ready write port and waits for the array to accept it before moving on.

Two commit sizes exist. A 64-bit commit uses the first two staging words and aligns the target to an 8-byte boundary. A 256-bit commit uses all eight words and aligns the target to a 32-byte boundary. The low bits of the commanded address are therefore discarded, and each word's offset comes only from its position. The staging words are frozen for the whole operation and can also be frozen by an external write-protect input. Size codes other than the two supported ones start nothing and raise a sticky error flag.

Top module: `flash_stage_top`

## Requirements
- R1: After reset, all eight staging words read as zero and `busy`, `done`, `err` and `fl_valid` are 0.
- R2: Staging word n (n = 0..7) sits at register byte address 0x28 + 4*n. All 32 bits can be written and read back. A read of any other address returns 0, and a write to any other address changes no staging word.
- R3: Size code 3'b001 (64-bit commit) produces exactly two transfers. Word 0 goes to `cmd_addr` with bits [2:0] = 000, and word 1 goes to `cmd_addr` with bits [2:0] = 100.
- R4: Size code 3'b010 (256-bit commit) produces exactly eight transfers in ascending order. Word n goes to `cmd_addr` with bits [4:0] replaced by 4*n.
- R5: A register write issued while `busy` is 1 leaves every staging word unchanged.
- R6: A register write issued while `wp_in` is 1 leaves every staging word unchanged.
- R7: A valid command seen with `busy` at 0 sets `busy` on the next cycle. `busy` stays at 1 until the last word is accepted. A command presented while `busy` is 1 is ignored.
- R8: Once `fl_valid` is 1, `fl_valid`, `fl_addr` and `fl_data` hold steady in every cycle in which `fl_ready` is 0.
- R9: In the cycle after the last word is accepted, `done` is 1 for exactly one cycle and `busy` returns to 0. The staging words keep their values after the commit.
- R10: A command with any other size code starts no transfer and sets `err` on the next cycle. `err` stays set until an `err_clr` pulse clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| wp_in | input | 1 | Write-protect; blocks staging writes while high |
| cmd_valid | input | 1 | Program command strobe |
| cmd_code | input | 3 | Size code: 3'b001 64-bit, 3'b010 256-bit |
| cmd_addr | input | 32 | Commanded target byte address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky unsupported-command flag |
| err_clr | input | 1 | Clears `err` |
| fl_valid | output | 1 | Word write request to the array |
| fl_addr | output | 32 | Word byte address |
| fl_data | output | 32 | Word data |
| fl_ready | input | 1 | Array accepts the current word |

## Verification
The hardest case to reach from the ports is a clash inside a live operation. A staging write and a second command must land while a word is still waiting on `fl_ready`. The write must then show up neither on `fl_data` nor in later read-back. The bench holds `fl_ready` low after a 64-bit command, drives both the write and a 256-bit command during that stall, then releases the handshake. It then checks that exactly two words left with the original data and that no further transfer began. Long stalls on individual words of a 256-bit commit also exercise the hold rule across every word position.

// File: rtl/flash_stage_pkg.sv
package flash_stage_pkg;

    localparam logic [2:0] CODE_SINGLE = 3'b001;
    localparam logic [2:0] CODE_QUAD   = 3'b010;

    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_QUAD   = 1'b1
    } commit_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } seq_state_e;

    function automatic logic code_is_valid(input logic [2:0] code);
        return (code == CODE_SINGLE) || (code == CODE_QUAD);
    endfunction

    function automatic commit_mode_e mode_of(input logic [2:0] code);
        return (code == CODE_QUAD) ? MODE_QUAD : MODE_SINGLE;
    endfunction

endpackage

// File: rtl/flash_stage_regs.sv
module flash_stage_regs #(
    parameter int              NUM_WORDS = 8,
    parameter int              DW        = 32,
    parameter int              RAW       = 8,
    parameter logic [RAW-1:0]  BASE      = 8'h28
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [RAW-1:0]           wr_addr,
    input  logic [DW-1:0]            wr_data,
    input  logic                     lock,
    input  logic [RAW-1:0]           rd_addr,
    output logic [DW-1:0]            rd_data,
    output logic [NUM_WORDS*DW-1:0]  words_flat
);

    logic [NUM_WORDS-1:0][DW-1:0] word_q;

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        localparam logic [RAW-1:0] OFF = BASE + RAW'(4 * i);
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q[i] <= '0;
            end else if (wr_en && !lock && (wr_addr == OFF)) begin
                word_q[i] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (rd_addr == BASE + RAW'(4 * i)) begin
                rd_data = word_q[i];
            end
        end
    end

    assign words_flat = word_q;

endmodule

// File: rtl/flash_stage_addr.sv
module flash_stage_addr
    import flash_stage_pkg::*;
#(
    parameter int AW           = 32,
    parameter int NUM_WORDS    = 8,
    parameter int SINGLE_WORDS = 2,
    parameter int IDX_W        = $clog2(NUM_WORDS)
) (
    input  logic [AW-1:0]    base,
    input  commit_mode_e     mode,
    input  logic [IDX_W-1:0] idx,
    output logic [AW-1:0]    addr
);

    localparam int S_BITS = $clog2(SINGLE_WORDS * 4);
    localparam int Q_BITS = $clog2(NUM_WORDS * 4);
    localparam logic [AW-1:0] S_MASK = {AW{1'b1}} << S_BITS;
    localparam logic [AW-1:0] Q_MASK = {AW{1'b1}} << Q_BITS;

    logic [AW-1:0] mask;
    logic [AW-1:0] offset;

    generate
        if (S_BITS == Q_BITS) begin : g_same_align
            assign mask = S_MASK;
        end else begin : g_mode_align
            assign mask = (mode == MODE_QUAD) ? Q_MASK : S_MASK;
        end
    endgenerate

    assign offset = AW'(idx) << 2;
    assign addr   = (base & mask) | offset;

endmodule

// File: rtl/flash_stage_seq.sv
module flash_stage_seq
    import flash_stage_pkg::*;
#(
    parameter int NUM_WORDS    = 8,
    parameter int SINGLE_WORDS = 2,
    parameter int AW           = 32,
    parameter int IDX_W        = $clog2(NUM_WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_code,
    input  logic [AW-1:0]    cmd_addr,
    input  logic             err_clr,
    input  logic             fl_ready,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             fl_valid,
    output commit_mode_e     mode,
    output logic [AW-1:0]    base,
    output logic [IDX_W-1:0] idx
);

    seq_state_e       state_q;
    commit_mode_e     mode_q;
    logic [AW-1:0]    base_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] last_idx;
    logic             done_q;
    logic             err_q;
    logic             accept;
    logic             reject;
    logic             step;
    logic             finish;

    assign accept   = (state_q == ST_IDLE) && cmd_valid && code_is_valid(cmd_code);
    assign reject   = (state_q == ST_IDLE) && cmd_valid && !code_is_valid(cmd_code);
    assign last_idx = (mode_q == MODE_QUAD) ? IDX_W'(NUM_WORDS - 1)
                                            : IDX_W'(SINGLE_WORDS - 1);
    assign step     = (state_q == ST_XFER) && fl_ready;
    assign finish   = step && (idx_q == last_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_SINGLE;
            base_q  <= '0;
            idx_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= finish;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q <= ST_XFER;
                        mode_q  <= mode_of(cmd_code);
                        base_q  <= cmd_addr;
                        idx_q   <= '0;
                    end
                end
                ST_XFER: begin
                    if (finish) begin
                        state_q <= ST_IDLE;
                        idx_q   <= '0;
                    end else if (step) begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else if (reject) begin
            err_q <= 1'b1;
        end else if (err_clr) begin
            err_q <= 1'b0;
        end
    end

    assign busy     = (state_q == ST_XFER);
    assign fl_valid = (state_q == ST_XFER);
    assign done     = done_q;
    assign err      = err_q;
    assign mode     = mode_q;
    assign base     = base_q;
    assign idx      = idx_q;

endmodule

// File: rtl/flash_stage_top.sv
module flash_stage_top
    import flash_stage_pkg::*;
#(
    parameter int             NUM_WORDS    = 8,
    parameter int             SINGLE_WORDS = 2,
    parameter int             DW           = 32,
    parameter int             AW           = 32,
    parameter int             RAW          = 8,
    parameter logic [RAW-1:0] REG_BASE     = 8'h28
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           reg_wr,
    input  logic [RAW-1:0] reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    input  logic           wp_in,
    input  logic           cmd_valid,
    input  logic [2:0]     cmd_code,
    input  logic [AW-1:0]  cmd_addr,
    output logic           busy,
    output logic           done,
    output logic           err,
    input  logic           err_clr,
    output logic           fl_valid,
    output logic [AW-1:0]  fl_addr,
    output logic [DW-1:0]  fl_data,
    input  logic           fl_ready
);

    localparam int IDX_W = $clog2(NUM_WORDS);

    logic [NUM_WORDS*DW-1:0] stage_flat;
    commit_mode_e            cur_mode;
    logic [AW-1:0]           cur_base;
    logic [IDX_W-1:0]        cur_idx;
    logic                    stage_lock;

    assign stage_lock = busy | wp_in;

    flash_stage_regs #(
        .NUM_WORDS (NUM_WORDS),
        .DW        (DW),
        .RAW       (RAW),
        .BASE      (REG_BASE)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (reg_wr),
        .wr_addr    (reg_addr),
        .wr_data    (reg_wdata),
        .lock       (stage_lock),
        .rd_addr    (reg_addr),
        .rd_data    (reg_rdata),
        .words_flat (stage_flat)
    );

    flash_stage_seq #(
        .NUM_WORDS    (NUM_WORDS),
        .SINGLE_WORDS (SINGLE_WORDS),
        .AW           (AW),
        .IDX_W        (IDX_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .cmd_addr  (cmd_addr),
        .err_clr   (err_clr),
        .fl_ready  (fl_ready),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .fl_valid  (fl_valid),
        .mode      (cur_mode),
        .base      (cur_base),
        .idx       (cur_idx)
    );

    flash_stage_addr #(
        .AW           (AW),
        .NUM_WORDS    (NUM_WORDS),
        .SINGLE_WORDS (SINGLE_WORDS),
        .IDX_W        (IDX_W)
    ) u_addr (
        .base (cur_base),
        .mode (cur_mode),
        .idx  (cur_idx),
        .addr (fl_addr)
    );

    assign fl_data = stage_flat[cur_idx*DW +: DW];

endmodule

// File: rtl/flash_stage_chk.sv
module flash_stage_chk
    import flash_stage_pkg::*;
#(
    parameter int NUM_WORDS = 8,
    parameter int DW        = 32,
    parameter int AW        = 32
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    cmd_valid,
    input logic [2:0]              cmd_code,
    input logic                    busy,
    input logic                    done,
    input logic                    err,
    input logic                    wp_in,
    input logic                    fl_valid,
    input logic                    fl_ready,
    input logic [AW-1:0]           fl_addr,
    input logic [DW-1:0]           fl_data,
    input logic [NUM_WORDS*DW-1:0] stage_flat
);

    AST_BUSY_FREEZES: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(stage_flat)); // R5

    AST_WP_FREEZES: assert property (@(posedge clk) disable iff (rst)
        wp_in |=> $stable(stage_flat)); // R6

    AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
        fl_valid && !fl_ready |=> fl_valid && $stable(fl_addr) && $stable(fl_data)); // R8

    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        fl_valid |-> (fl_addr[1:0] == 2'b00)); // R4

    AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !busy && code_is_valid(cmd_code) |=> busy); // R7

    AST_BAD_CODE_ERR: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !busy && !code_is_valid(cmd_code) |=> err && !busy); // R10

    AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R9

endmodule

bind flash_stage_top flash_stage_chk #(
    .NUM_WORDS (NUM_WORDS),
    .DW        (DW),
    .AW        (AW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .wp_in      (wp_in),
    .fl_valid   (fl_valid),
    .fl_ready   (fl_ready),
    .fl_addr    (fl_addr),
    .fl_data    (fl_data),
    .stage_flat (stage_flat)
);

// File: tb/flash_stage_top_test.sv
module flash_stage_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        wp_in = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_code = 3'b000;
    logic [31:0] cmd_addr = '0;
    logic        busy, done, err;
    logic        err_clr = 1'b0;
    logic        fl_valid;
    logic [31:0] fl_addr, fl_data;
    logic        fl_ready = 1'b0;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    logic [31:0] model [8];

    flash_stage_top uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wp_in(wp_in),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
        .busy(busy), .done(done), .err(err), .err_clr(err_clr),
        .fl_valid(fl_valid), .fl_addr(fl_addr), .fl_data(fl_data),
        .fl_ready(fl_ready)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            fails = fails + 1;
            $display("FAIL watchdog R7: run hung, cycles %0d expected below %0d", cycles, 20000);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests = tests + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic check_all_words(input string tag);
        logic [31:0] v;
        for (int i = 0; i < 8; i++) begin
            rd_reg(8'h28 + 8'(4 * i), v);
            chk(v === model[i], tag, v, model[i]);
        end
    endtask

    // Runs one command and serves the array side, stalling each word.
    task automatic run_cmd(input logic [2:0] code, input logic [31:0] a,
                           input int nwords, input int stall, input string tag);
        logic [31:0] mask;
        logic [31:0] ea;
        mask = (nwords == 2) ? 32'hFFFF_FFF8 : 32'hFFFF_FFE0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = code; cmd_addr = a; fl_ready = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy === 1'b1, "R7 busy after accept", 32'(busy), 32'd1);
        for (int k = 0; k < nwords; k++) begin
            ea = (a & mask) | 32'(k * 4);
            for (int s = 0; s <= stall; s++) begin
                chk(fl_valid === 1'b1, "R8 valid held", 32'(fl_valid), 32'd1);
                chk(fl_addr === ea, {tag, " addr"}, fl_addr, ea);
                chk(fl_data === model[k], {tag, " data"}, fl_data, model[k]);
                if (s < stall) @(negedge clk);
            end
            fl_ready = 1'b1;
            @(negedge clk);
            fl_ready = 1'b0;
        end
        chk(done === 1'b1, "R9 done pulse", 32'(done), 32'd1);
        chk(busy === 1'b0, "R7 busy cleared", 32'(busy), 32'd0);
        @(negedge clk);
        chk(done === 1'b0, "R9 done one cycle", 32'(done), 32'd0);
        chk(fl_valid === 1'b0, {tag, " no extra word"}, 32'(fl_valid), 32'd0);
    endtask

    task automatic test_reset();
        chk(busy === 1'b0, "R1 busy", 32'(busy), 32'd0);
        chk(done === 1'b0, "R1 done", 32'(done), 32'd0);
        chk(err === 1'b0, "R1 err", 32'(err), 32'd0);
        chk(fl_valid === 1'b0, "R1 fl_valid", 32'(fl_valid), 32'd0);
        check_all_words("R1 word zero");
    endtask

    task automatic test_regs();
        logic [31:0] v;
        for (int i = 0; i < 8; i++) begin
            model[i] = 32'hA5000000 ^ (32'(i) * 32'h0101_1011) ^ (32'h1 << (i * 4));
            wr_reg(8'h28 + 8'(4 * i), model[i]);
        end
        check_all_words("R2 readback");
        wr_reg(8'h24, 32'hFFFF_FFFF);
        wr_reg(8'h48, 32'hFFFF_FFFF);
        rd_reg(8'h24, v);
        chk(v === 32'h0, "R2 unmapped 0x24", v, 32'h0);
        rd_reg(8'h48, v);
        chk(v === 32'h0, "R2 unmapped 0x48", v, 32'h0);
        check_all_words("R2 unmapped write");
    endtask

    task automatic test_single();
        run_cmd(3'b001, 32'h1234_567D, 2, 2, "R3");
        check_all_words("R9 words kept");
    endtask

    task automatic test_quad();
        run_cmd(3'b010, 32'hABCD_EF3F, 8, 1, "R4");
        check_all_words("R9 words kept quad");
        run_cmd(3'b010, 32'h0000_0100, 8, 0, "R4 aligned");
    endtask

    task automatic test_busy_lock();
        logic [31:0] v;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = 3'b001; cmd_addr = 32'h8000_0044; fl_ready = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0;
        // Staging write and second command during the stall
        reg_wr = 1'b1; reg_addr = 8'h28; reg_wdata = 32'hDEAD_BEEF;
        cmd_valid = 1'b1; cmd_code = 3'b010; cmd_addr = 32'h0000_0000;
        @(negedge clk);
        reg_wr = 1'b0; cmd_valid = 1'b0;
        chk(fl_addr === 32'h8000_0040, "R5 word0 addr", fl_addr, 32'h8000_0040);
        chk(fl_data === model[0], "R5 word0 data", fl_data, model[0]);
        fl_ready = 1'b1;
        @(negedge clk);
        chk(fl_addr === 32'h8000_0044, "R7 word1 addr", fl_addr, 32'h8000_0044);
        @(negedge clk);
        fl_ready = 1'b0;
        chk(done === 1'b1, "R7 done after two", 32'(done), 32'd1);
        @(negedge clk);
        chk(busy === 1'b0, "R7 second cmd ignored busy", 32'(busy), 32'd0);
        chk(fl_valid === 1'b0, "R7 second cmd ignored valid", 32'(fl_valid), 32'd0);
        rd_reg(8'h28, v);
        chk(v === model[0], "R5 word0 kept", v, model[0]);
    endtask

    task automatic test_wp();
        logic [31:0] v;
        wp_in = 1'b1;
        wr_reg(8'h30, 32'h0BAD_F00D);
        wp_in = 1'b0;
        rd_reg(8'h30, v);
        chk(v === model[2], "R6 protected write", v, model[2]);
        model[2] = 32'h600D_CAFE;
        wr_reg(8'h30, model[2]);
        rd_reg(8'h30, v);
        chk(v === model[2], "R6 unprotected write", v, model[2]);
    endtask

    task automatic test_bad_code();
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = 3'b111; cmd_addr = 32'h0000_1000;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(err === 1'b1, "R10 err set", 32'(err), 32'd1);
        chk(busy === 1'b0, "R10 no start", 32'(busy), 32'd0);
        chk(fl_valid === 1'b0, "R10 no word", 32'(fl_valid), 32'd0);
        repeat (3) @(negedge clk);
        chk(err === 1'b1, "R10 err sticky", 32'(err), 32'd1);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        chk(err === 1'b0, "R10 err cleared", 32'(err), 32'd0);
        run_cmd(3'b001, 32'h0000_2003, 2, 0, "R10 recover");
    endtask

    initial begin
        for (int i = 0; i < 8; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_regs();
        test_single();
        test_quad();
        test_busy_lock();
        test_wp();
        test_bad_code();
        repeat (2) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule